// File: doc/BRIEF.md
# Automatic Controller Serial Poller

The block reads two game-controller ports once per frame without software involvement. Each port has two serial data lines. When automatic polling is enabled, a new-line strobe that arrives on the start line starts a poll. The start line depends on whether the frame uses overscan.

A poll has three parts:
- a latch pulse to both ports;
- sixteen serial clock pulses;
- one data sample on all four lines in the low phase before each clock pulse.

The four lines fill four 16-bit result words, most significant bit first. The words change all at once, when the poll ends. Software reads each word a byte at a time through a small select input. A busy flag shows that a poll is in progress.

Top module: `joy_autopoll`

## Requirements
- R1: A poll starts only on a cycle where newline_i is 1, enable_i is 1, and line_i equals 227 with overscan_i 0, or 242 with overscan_i 1. A strobe on any other line, or one with enable_i at 0, starts nothing.
- R2: A poll first drives latch_o high for PULSE_W cycles (default 6). After that, each of the sixteen serial bits has a low phase of PULSE_W cycles followed by a ser_clk_o high phase of PULSE_W cycles. latch_o and ser_clk_o are never high together.
- R3: Exactly 16 samples are taken per poll, so ser_clk_o rises exactly 16 times. Each sample is taken in the last cycle of a low phase.
- R4: The first bit sampled lands in bit 15 of its word. Each later bit lands one position lower, so the last one lands in bit 0.
- R5: Word 1 takes port0_d_i[0], word 2 takes port1_d_i[0], word 3 takes port0_d_i[1] and word 4 takes port1_d_i[1].
- R6: busy_o is 1 from the first latch cycle until the poll completes. The result words change only on the clock edge where busy_o falls.
- R7: A start condition that arrives while busy_o is 1 is ignored. No new latch pulse is issued, and the running poll completes with its original data.
- R8: rd_data_o returns one byte of the result words. rd_sel_i[2:1] picks the word (0 is word 1, 3 is word 4). rd_sel_i[0] picks the byte: 1 for bits 15:8, 0 for bits 7:0. The path from rd_sel_i to rd_data_o is combinational.
- R9: While reset is held, and after it is released, all result words are 0 and busy_o, latch_o and ser_clk_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Automatic polling enable |
| overscan_i | input | 1 | Frame uses overscan, which selects the start line |
| newline_i | input | 1 | One-cycle strobe when line_i advances |
| line_i | input | 9 | Current vertical line |
| port0_d_i | input | 2 | Serial data lines of port 0 |
| port1_d_i | input | 2 | Serial data lines of port 1 |
| latch_o | output | 1 | Latch strobe to both ports |
| ser_clk_o | output | 1 | Serial clock to both ports |
| busy_o | output | 1 | Poll in progress |
| rd_sel_i | input | 3 | Byte select for readback |
| rd_data_o | output | 8 | Selected result byte |

## Verification
Two events can meet while a poll is running: a start condition and an active poll. To force this, the bench pulses the start line mid-poll after loading different values into the controller stubs. It then checks three things: no second latch occurred, the clock count is still sixteen, and the results match the first set of values. The other meeting point is a byte read taken while a poll is in progress. The bench reads all eight bytes mid-poll and expects the previous poll's values.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned WORD_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/joy_seq.sv
module joy_seq
  import joy_pkg::*;
#(
  parameter int unsigned PULSE_W = 6,
  parameter int unsigned BITS    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic latch_o,
  output logic ser_clk_o,
  output logic sample_o,
  output logic done_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);
  localparam int unsigned BW = (BITS > 1) ? $clog2(BITS) : 1;

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bit_q;
  logic           last;

  assign last      = (cnt_q == CW'(PULSE_W - 1));
  assign latch_o   = (state_q == ST_LATCH);
  assign ser_clk_o = (state_q == ST_HIGH);
  assign busy_o    = (state_q != ST_IDLE);
  assign sample_o  = (state_q == ST_LOW) && last;
  assign done_o    = (state_q == ST_HIGH) && last && (bit_q == BW'(BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LATCH;
            cnt_q   <= '0;
            bit_q   <= '0;
          end
        end
        ST_LATCH: begin
          if (last) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_LOW: begin
          if (last) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HIGH: begin
          if (last) begin
            cnt_q <= '0;
            if (bit_q == BW'(BITS - 1)) state_q <= ST_IDLE;
            else begin
              state_q <= ST_LOW;
              bit_q   <= bit_q + 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/joy_lanes.sv
module joy_lanes #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_i,
  input  logic                      commit_i,
  input  logic [LANES-1:0]          data_i,
  output logic [LANES*WORD_W-1:0]   res_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WORD_W-1:0] sh_q, res_q;
    // shift toward MSB: first sample ends in the top bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else if (sample_i) sh_q <= {sh_q[WORD_W-2:0], data_i[k]};
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else if (commit_i) res_q <= sh_q;
    end
    assign res_o[k*WORD_W +: WORD_W] = res_q;
  end
endmodule

// File: rtl/joy_rdmux.sv
module joy_rdmux #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 16
) (
  input  logic [LANES*WORD_W-1:0]            words_i,
  input  logic [$clog2(LANES*WORD_W/8)-1:0]  sel_i,
  output logic [7:0]                         data_o
);
  localparam int unsigned NB = LANES * WORD_W / 8;
  logic [7:0] bytes [NB];
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bytes[b] = words_i[b*8 +: 8];
  end
  assign data_o = bytes[sel_i];
endmodule

// File: rtl/joy_autopoll.sv
module joy_autopoll
  import joy_pkg::*;
#(
  parameter int unsigned PULSE_W  = 6,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned LINE_STD = 227,
  parameter int unsigned LINE_OVS = 242
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              overscan_i,
  input  logic              newline_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        port0_d_i,
  input  logic [1:0]        port1_d_i,
  output logic              latch_o,
  output logic              ser_clk_o,
  output logic              busy_o,
  input  logic [2:0]        rd_sel_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned RES_W = NUM_WORDS * WORD_W;

  logic [LINE_W-1:0]    start_line;
  logic                 start;
  logic                 sample, done;
  logic [NUM_WORDS-1:0] lane_d;
  logic [RES_W-1:0]     res_flat;

  assign start_line = overscan_i ? LINE_W'(LINE_OVS) : LINE_W'(LINE_STD);
  assign start      = enable_i && newline_i && (line_i == start_line) && !busy_o;
  // word order: port0 bit0, port1 bit0, port0 bit1, port1 bit1
  assign lane_d     = {port1_d_i[1], port0_d_i[1], port1_d_i[0], port0_d_i[0]};

  joy_seq #(.PULSE_W(PULSE_W), .BITS(WORD_W)) i_seq (
    .clk_i, .rst_ni, .start_i(start), .latch_o, .ser_clk_o,
    .sample_o(sample), .done_o(done), .busy_o
  );

  joy_lanes #(.LANES(NUM_WORDS), .WORD_W(WORD_W)) i_lanes (
    .clk_i, .rst_ni, .sample_i(sample), .commit_i(done),
    .data_i(lane_d), .res_o(res_flat)
  );

  joy_rdmux #(.LANES(NUM_WORDS), .WORD_W(WORD_W)) i_rdmux (
    .words_i(res_flat), .sel_i(rd_sel_i), .data_o(rd_data_o)
  );
endmodule

// File: rtl/joy_autopoll_chk.sv
module joy_autopoll_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        latch_o,
  input logic        ser_clk_o,
  input logic        busy_o,
  input logic [63:0] res_flat
);
  logic       clk_d;
  logic [4:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      clk_d <= ser_clk_o;
      if (latch_o) rise_cnt <= '0;
      else if (ser_clk_o && !clk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(latch_o && ser_clk_o));
  a_r6_busy_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o || ser_clk_o) |-> busy_o);
  a_r6_commit_only_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_flat) |-> $fell(busy_o));
  a_r7_latch_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> !$past(busy_o));
  a_r3_sixteen_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (rise_cnt == 5'd16));
endmodule

bind joy_autopoll joy_autopoll_chk i_chk (
  .clk_i, .rst_ni, .latch_o, .ser_clk_o, .busy_o, .res_flat
);

// File: tb/test_joy_autopoll.sv
module test_joy_autopoll;
  localparam int PW = 6;

  logic       clk = 0, rst_ni = 0;
  logic       enable = 0, overscan = 0, newline = 0;
  logic [8:0] line = 0;
  logic [1:0] p0, p1;
  logic       latch, sclk, busy;
  logic [2:0] rd_sel = 0;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat_hi = 0, clk_hi = 0, lat_rise = 0, clk_rise = 0;
  logic lat_d = 0, clk_dd = 0;
  logic [15:0] stub_val [4];
  logic [15:0] sr [4];
  logic [15:0] exp_w [4];

  always #10 clk = ~clk;

  joy_autopoll #(.PULSE_W(PW)) i_joy_autopoll (
    .clk_i(clk), .rst_ni, .enable_i(enable), .overscan_i(overscan),
    .newline_i(newline), .line_i(line), .port0_d_i(p0), .port1_d_i(p1),
    .latch_o(latch), .ser_clk_o(sclk), .busy_o(busy),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  // controller stubs: load on latch, shift on serial clock rise
  always @(posedge latch) for (int k = 0; k < 4; k++) sr[k] <= stub_val[k];
  always @(posedge sclk)  for (int k = 0; k < 4; k++) sr[k] <= {sr[k][14:0], 1'b0};
  assign p0 = {sr[2][15], sr[0][15]};
  assign p1 = {sr[3][15], sr[1][15]};

  always @(negedge clk) begin
    cyc++;
    if (latch) lat_hi++;
    if (sclk)  clk_hi++;
    if (latch && !lat_d) lat_rise++;
    if (sclk && !clk_dd) clk_rise++;
    lat_d = latch; clk_dd = sclk;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int s);
    return s[0] ? exp_w[s>>1][15:8] : exp_w[s>>1][7:0];
  endfunction

  task automatic check_bytes(string req);
    for (int s = 0; s < 8; s++) begin
      rd_sel = s[2:0];
      #1;
      check(req, rd_data, exp_byte(s));
    end
  endtask

  task automatic strobe(logic en, logic ovs, int ln);
    @(negedge clk);
    enable = en; overscan = ovs; line = ln[8:0]; newline = 1;
    @(negedge clk);
    newline = 0;
  endtask

  task automatic load_stub();
    for (int k = 0; k < 4; k++) stub_val[k] = $urandom() & 16'hffff;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic full_poll(logic ovs, string req);
    load_stub();
    lat_hi = 0; clk_hi = 0; lat_rise = 0; clk_rise = 0;
    strobe(1, ovs, ovs ? 242 : 227);
    check({req, "/R6 busy"}, busy, 1);
    wait_idle();
    for (int k = 0; k < 4; k++) exp_w[k] = stub_val[k];
    check("R2 latch width", lat_hi, PW);
    check("R2 clk high cycles", clk_hi, 16 * PW);
    check("R3 clk rises", clk_rise, 16);
    check_bytes({req, "/R4/R5/R8 data"});
  endtask

  task automatic no_start(logic en, logic ovs, int ln, string req);
    lat_rise = 0;
    strobe(en, ovs, ln);
    repeat (3) @(negedge clk);
    check(req, busy, 0);
    check(req, lat_rise, 0);
    check_bytes({req, " results kept"});
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int k = 0; k < 4; k++) begin stub_val[k] = 0; sr[k] = 0; exp_w[k] = 0; end
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 latch", latch, 0);
    check("R9 sclk", sclk, 0);
    check_bytes("R9 reset bytes");
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check("R9 busy after reset", busy, 0);

    // directed patterns for bit order and lane mapping
    stub_val[0] = 16'h8001; stub_val[1] = 16'h0000;
    stub_val[2] = 16'hffff; stub_val[3] = 16'h1234;
    strobe(1, 0, 227);
    wait_idle();
    exp_w[0] = 16'h8001; exp_w[1] = 16'h0000; exp_w[2] = 16'hffff; exp_w[3] = 16'h1234;
    check_bytes("R4/R5 directed");

    // random polls in both modes
    for (int i = 0; i < 8; i++) full_poll(i[0], "R1");

    // start conditions that must not fire
    no_start(1, 1, 227, "R1 overscan wrong line");
    no_start(1, 0, 242, "R1 normal wrong line");
    no_start(0, 0, 227, "R1 disabled");
    no_start(1, 0, 226, "R1 adjacent line");

    // retrigger while busy, and reads while busy
    load_stub();
    lat_rise = 0; clk_rise = 0;
    strobe(1, 0, 227);
    repeat (40) @(negedge clk);
    check_bytes("R6 results stable mid-poll");
    begin
      logic [15:0] first [4];
      for (int k = 0; k < 4; k++) first[k] = stub_val[k];
      for (int k = 0; k < 4; k++) stub_val[k] = ~first[k];
      strobe(1, 0, 227);
      wait_idle();
      for (int k = 0; k < 4; k++) exp_w[k] = first[k];
    end
    check("R7 single latch", lat_rise, 1);
    check("R7 sixteen clocks", clk_rise, 16);
    check_bytes("R7 original data");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule